// File: doc/BRIEF.md
# Vectored Interrupt Controller with Trap and Boot Slots

This block gathers interrupt events and, for whichever request wins, gives the CPU a 16-bit vector-table address. Sources are eight external lines, one top-level channel and a divide-by-zero trap strobe. Each external line has its own trigger edge and enable bit. The top-level channel is fed either from a non-maskable pin or from a watchdog strobe. After every reset, a boot request also waits to be serviced. Each source has a pending bit. The highest-priority pending request that is allowed through is offered to the CPU over a valid/ready handshake.

The vector address is formed by hardware. External channels share one software-written vector base: the base fills the upper bits of the 8-bit table offset, the channel index fills the lower bits, and the lowest bit is zero because entries are 16-bit words. External and top-level entries sit in the segment on `int_seg_i`. The trap entry sits in the current code segment on `code_seg_i`. The boot entry is at address zero. A flag tells the CPU whether the flag register is to be saved, which is not the case for the trap or for boot.

Handshake rules: `irq_valid_o` is the valid and `cpu_ack_i` is the ready. While ack is low, every pending bit is held and nothing is lost. The offered vector is not frozen, though: a higher-priority request that arrives before the ack takes the grant. The transfer happens in the cycle where both are high. At that clock edge the pending bit of the granted source is cleared, and only that bit.

Top module: `vic_trap_ctrl`

## Requirements
- R1: While reset is active, all pending bits are cleared and the boot request is set. After reset, `irq_valid_o`=1 with `kind_o`=3, `vec_addr_o`=0000h and `save_flags_o`=0. An ack then removes the boot request.
- R2: Each external line goes through a two-flop synchronizer and a registered previous value. Its pending bit is set at the third rising clock edge after the line changes. `edge_rise_i[k]`=1 selects the rising edge of line k and 0 selects the falling edge. The opposite edge sets nothing.
- R3: The vector address of external channel k is {`int_seg_i`, `vec_base_i`[3:0], k[2:0], 1'b0}, with `kind_o`=0, `chan_o`=k and `save_flags_o`=1.
- R4: A pending external channel k is offered only when `glb_en_i`=1 and `chan_en_i[k]`=1. While it is disabled it stays pending and is offered once it is enabled again.
- R5: Among the offered external channels, the lowest index wins.
- R6: With `top_src_i`=0, a rising edge on `nmi_pin_i` sets the top-level pending bit three edges later, through the same synchronizer. That request ignores `glb_en_i` and the per-channel enables.
- R7: With `top_src_i`=1, a one-cycle `wdog_req_i` strobe sets the top-level pending bit at the next edge. That request is offered only while `glb_en_i`=1.
- R8: The top-level grant gives `kind_o`=2, `vec_addr_o`={`int_seg_i`, 04h} and `save_flags_o`=1.
- R9: A one-cycle `div0_trap_i` strobe sets the trap pending bit at the next edge. The trap is not maskable and gives `kind_o`=1, `vec_addr_o`={`code_seg_i`, 02h} and `save_flags_o`=0.
- R10: Priority, from highest to lowest: boot, top-level, trap, external channels.
- R11: When `irq_valid_o` and `cpu_ack_i` are both high, the clock edge clears only the granted pending bit. All other pending requests remain and are offered next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; also arms the boot request |
| ext_line_i | input | 8 | External interrupt lines (asynchronous) |
| edge_rise_i | input | 8 | Per line: 1 rising edge, 0 falling edge |
| chan_en_i | input | 8 | Per-channel enable for the external channels |
| glb_en_i | input | 1 | Global enable for maskable requests |
| nmi_pin_i | input | 1 | Non-maskable pin (asynchronous, rising edge) |
| wdog_req_i | input | 1 | Watchdog strobe, synchronous, one cycle |
| top_src_i | input | 1 | Top-level source: 0 pin, 1 watchdog |
| div0_trap_i | input | 1 | Divide-by-zero trap strobe, one cycle |
| int_seg_i | input | 8 | Segment holding the interrupt vector table |
| code_seg_i | input | 8 | Current code segment (trap vector) |
| vec_base_i | input | 4 | Software part of the external vector offset |
| irq_valid_o | output | 1 | A request is offered |
| cpu_ack_i | input | 1 | CPU takes the offered request |
| vec_addr_o | output | 16 | Vector-table address of the offered request |
| kind_o | output | 2 | 0 external, 1 trap, 2 top-level, 3 boot |
| chan_o | output | 3 | External channel index (0 for other kinds) |
| save_flags_o | output | 1 | 1 if the CPU saves the flag register |

## Verification
The results have different latencies. A line edge reaches the outputs three edges after the line changes. Trap and watchdog strobes reach them one edge after they are sampled. Enables, segments and the base act in the same cycle, because the path from pending to outputs is combinational. An ack takes effect at the edge where it is sampled. The bench drives inputs on falling clock edges and samples exactly that many falling edges later. For the edge latency it checks one edge early, where no request may be seen, and then at the due edge, where it must be.

// File: rtl/vic_pkg.sv
package vic_pkg;
  typedef enum logic [1:0] {
    K_EXT  = 2'd0,
    K_TRAP = 2'd1,
    K_TOP  = 2'd2,
    K_BOOT = 2'd3
  } vic_kind_e;

  // Fixed word slots inside a vector segment
  localparam int TRAP_SLOT = 2;
  localparam int TOP_SLOT  = 4;
endpackage

// File: rtl/vic_edge_det.sv
module vic_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic rise_sel_i,
  output logic hit_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  // Edge seen between the synchronized level and its registered copy
  always_comb begin
    if (rise_sel_i) hit_o = sync_q[SYNC_STAGES-1] & ~prev_q;
    else            hit_o = ~sync_q[SYNC_STAGES-1] & prev_q;
  end
endmodule

// File: rtl/vic_prio_sel.sv
module vic_prio_sel
  import vic_pkg::*;
#(
  parameter int NUM_EXT = 8,
  localparam int IDX_W = $clog2(NUM_EXT)
) (
  input  logic               boot_req_i,
  input  logic               top_req_i,
  input  logic               trap_req_i,
  input  logic [NUM_EXT-1:0] ext_req_i,
  output logic               valid_o,
  output vic_kind_e          kind_o,
  output logic [IDX_W-1:0]   chan_o
);
  logic [IDX_W-1:0] low_idx;

  always_comb begin
    low_idx = '0;
    for (int i = NUM_EXT - 1; i >= 0; i--) begin
      if (ext_req_i[i]) low_idx = IDX_W'(i);
    end
  end

  always_comb begin
    valid_o = 1'b1;
    kind_o  = K_EXT;
    chan_o  = '0;
    if (boot_req_i)        kind_o = K_BOOT;
    else if (top_req_i)    kind_o = K_TOP;
    else if (trap_req_i)   kind_o = K_TRAP;
    else if (|ext_req_i)   chan_o = low_idx;
    else                   valid_o = 1'b0;
  end
endmodule

// File: rtl/vic_vec_form.sv
module vic_vec_form
  import vic_pkg::*;
#(
  parameter int NUM_EXT = 8,
  parameter int SEG_W   = 8,
  parameter int OFF_W   = 8,
  localparam int IDX_W  = $clog2(NUM_EXT),
  localparam int BASE_W = OFF_W - IDX_W - 1,
  localparam int ADDR_W = SEG_W + OFF_W
) (
  input  vic_kind_e          kind_i,
  input  logic [IDX_W-1:0]   chan_i,
  input  logic [SEG_W-1:0]   int_seg_i,
  input  logic [SEG_W-1:0]   code_seg_i,
  input  logic [BASE_W-1:0]  base_i,
  output logic [ADDR_W-1:0]  addr_o,
  output logic               save_flags_o
);
  always_comb begin
    unique case (kind_i)
      K_BOOT: begin
        addr_o       = '0;
        save_flags_o = 1'b0;
      end
      K_TOP: begin
        addr_o       = {int_seg_i, OFF_W'(TOP_SLOT)};
        save_flags_o = 1'b1;
      end
      K_TRAP: begin
        addr_o       = {code_seg_i, OFF_W'(TRAP_SLOT)};
        save_flags_o = 1'b0;
      end
      default: begin
        addr_o       = {int_seg_i, base_i, chan_i, 1'b0};
        save_flags_o = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/vic_trap_ctrl.sv
module vic_trap_ctrl
  import vic_pkg::*;
#(
  parameter int NUM_EXT     = 8,
  parameter int SYNC_STAGES = 2,
  parameter int SEG_W       = 8,
  parameter int OFF_W       = 8,
  localparam int IDX_W  = $clog2(NUM_EXT),
  localparam int BASE_W = OFF_W - IDX_W - 1,
  localparam int ADDR_W = SEG_W + OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EXT-1:0] ext_line_i,
  input  logic [NUM_EXT-1:0] edge_rise_i,
  input  logic [NUM_EXT-1:0] chan_en_i,
  input  logic               glb_en_i,
  input  logic               nmi_pin_i,
  input  logic               wdog_req_i,
  input  logic               top_src_i,
  input  logic               div0_trap_i,
  input  logic [SEG_W-1:0]   int_seg_i,
  input  logic [SEG_W-1:0]   code_seg_i,
  input  logic [BASE_W-1:0]  vec_base_i,
  output logic               irq_valid_o,
  input  logic               cpu_ack_i,
  output logic [ADDR_W-1:0]  vec_addr_o,
  output logic [1:0]         kind_o,
  output logic [IDX_W-1:0]   chan_o,
  output logic               save_flags_o
);
  logic [NUM_EXT-1:0] ext_hit;
  logic [NUM_EXT-1:0] ext_pend;
  logic [NUM_EXT-1:0] ext_req;
  logic [NUM_EXT-1:0] ext_clr;
  logic               nmi_hit;
  logic               boot_pend, top_pend, trap_pend;
  logic               top_req, top_set;
  logic               take;
  vic_kind_e          win_kind;
  logic [IDX_W-1:0]   win_chan;

  // One synchronizer and edge detector per external line
  for (genvar g = 0; g < NUM_EXT; g++) begin : g_ext
    vic_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_i     (ext_line_i[g]),
      .rise_sel_i (edge_rise_i[g]),
      .hit_o      (ext_hit[g])
    );
  end

  vic_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_nmi_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_i     (nmi_pin_i),
    .rise_sel_i (1'b1),
    .hit_o      (nmi_hit)
  );

  assign take    = irq_valid_o & cpu_ack_i;
  assign top_set = top_src_i ? wdog_req_i : nmi_hit;

  // Only the granted external channel is cleared
  always_comb begin
    ext_clr = '0;
    if (take && win_kind == K_EXT) ext_clr[win_chan] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      boot_pend <= 1'b1;
      top_pend  <= 1'b0;
      trap_pend <= 1'b0;
      ext_pend  <= '0;
    end else begin
      if (take && win_kind == K_BOOT) boot_pend <= 1'b0;
      top_pend  <= (top_pend  & ~(take && win_kind == K_TOP))  | top_set;
      trap_pend <= (trap_pend & ~(take && win_kind == K_TRAP)) | div0_trap_i;
      ext_pend  <= (ext_pend & ~ext_clr) | ext_hit;
    end
  end

  // Gating is applied to the request, not to the pending state
  assign top_req = top_pend & (~top_src_i | glb_en_i);
  assign ext_req = ext_pend & chan_en_i & {NUM_EXT{glb_en_i}};

  vic_prio_sel #(.NUM_EXT(NUM_EXT)) u_prio (
    .boot_req_i (boot_pend),
    .top_req_i  (top_req),
    .trap_req_i (trap_pend),
    .ext_req_i  (ext_req),
    .valid_o    (irq_valid_o),
    .kind_o     (win_kind),
    .chan_o     (win_chan)
  );

  vic_vec_form #(
    .NUM_EXT (NUM_EXT),
    .SEG_W   (SEG_W),
    .OFF_W   (OFF_W)
  ) u_vec (
    .kind_i       (win_kind),
    .chan_i       (win_chan),
    .int_seg_i    (int_seg_i),
    .code_seg_i   (code_seg_i),
    .base_i       (vec_base_i),
    .addr_o       (vec_addr_o),
    .save_flags_o (save_flags_o)
  );

  assign kind_o = win_kind;
  assign chan_o = win_chan;
endmodule

// File: rtl/vic_trap_ctrl_chk.sv
module vic_trap_ctrl_chk
  import vic_pkg::*;
#(
  parameter int NUM_EXT = 8,
  parameter int SEG_W   = 8,
  parameter int OFF_W   = 8,
  localparam int IDX_W  = $clog2(NUM_EXT),
  localparam int ADDR_W = SEG_W + OFF_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               irq_valid_o,
  input logic               cpu_ack_i,
  input logic [1:0]         kind_o,
  input logic [IDX_W-1:0]   chan_o,
  input logic [ADDR_W-1:0]  vec_addr_o,
  input logic               save_flags_o,
  input logic [SEG_W-1:0]   code_seg_i,
  input logic [SEG_W-1:0]   int_seg_i,
  input logic               glb_en_i,
  input logic [NUM_EXT-1:0] chan_en_i,
  input logic               top_src_i,
  input logic               top_pend,
  input logic [NUM_EXT-1:0] ext_pend
);
  logic [NUM_EXT-1:0] sel_oh;
  logic [NUM_EXT-1:0] below_oh;
  assign sel_oh   = NUM_EXT'(1) << chan_o;
  assign below_oh = sel_oh - NUM_EXT'(1);

  // R9
  trap_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid_o && kind_o == K_TRAP) |->
      (vec_addr_o == {code_seg_i, OFF_W'(TRAP_SLOT)} && !save_flags_o));

  // R8
  top_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid_o && kind_o == K_TOP) |->
      (vec_addr_o == {int_seg_i, OFF_W'(TOP_SLOT)} && save_flags_o));

  // R4
  ext_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid_o && kind_o == K_EXT) |-> (glb_en_i && chan_en_i[chan_o]));

  // R5
  ext_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid_o && kind_o == K_EXT) |-> ((ext_pend & chan_en_i & below_oh) == '0));

  // R6
  nmi_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (top_pend && !top_src_i && kind_o != K_BOOT) |-> (irq_valid_o && kind_o == K_TOP));

  // R11
  others_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid_o && cpu_ack_i && kind_o == K_EXT) |=>
      ((ext_pend & $past(ext_pend & ~sel_oh)) == $past(ext_pend & ~sel_oh)));
endmodule

bind vic_trap_ctrl vic_trap_ctrl_chk #(
  .NUM_EXT (NUM_EXT),
  .SEG_W   (SEG_W),
  .OFF_W   (OFF_W)
) u_vic_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .irq_valid_o  (irq_valid_o),
  .cpu_ack_i    (cpu_ack_i),
  .kind_o       (kind_o),
  .chan_o       (chan_o),
  .vec_addr_o   (vec_addr_o),
  .save_flags_o (save_flags_o),
  .code_seg_i   (code_seg_i),
  .int_seg_i    (int_seg_i),
  .glb_en_i     (glb_en_i),
  .chan_en_i    (chan_en_i),
  .top_src_i    (top_src_i),
  .top_pend     (top_pend),
  .ext_pend     (ext_pend)
);

// File: tb/test_vic_trap_ctrl.sv
module test_vic_trap_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] ISEG = 8'h3C;
  localparam logic [7:0] CSEG = 8'h91;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] ext_line, edge_rise, chan_en;
  logic       glb_en, nmi_pin, wdog_req, top_src, div0;
  logic [3:0] vec_base;
  logic       irq_valid, cpu_ack, save_flags;
  logic [15:0] vec_addr;
  logic [1:0] kind;
  logic [2:0] chan;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vic_trap_ctrl i_vic_trap_ctrl (
    .clk (clk), .rst_n (rst_n), .ext_line_i (ext_line), .edge_rise_i (edge_rise),
    .chan_en_i (chan_en), .glb_en_i (glb_en), .nmi_pin_i (nmi_pin),
    .wdog_req_i (wdog_req), .top_src_i (top_src), .div0_trap_i (div0),
    .int_seg_i (ISEG), .code_seg_i (CSEG), .vec_base_i (vec_base),
    .irq_valid_o (irq_valid), .cpu_ack_i (cpu_ack), .vec_addr_o (vec_addr),
    .kind_o (kind), .chan_o (chan), .save_flags_o (save_flags)
  );

  // fire, enables, glb, base, expected valid, expected channel
  localparam int NV = 7;
  localparam logic [24:0] VECS [NV] = '{
    {8'h01, 8'hFF, 1'b1, 4'h3, 1'b1, 3'd0},
    {8'h88, 8'hFF, 1'b1, 4'h5, 1'b1, 3'd3},
    {8'h06, 8'hFB, 1'b1, 4'hA, 1'b1, 3'd1},
    {8'h10, 8'hEF, 1'b1, 4'h1, 1'b0, 3'd0},
    {8'h80, 8'hFF, 1'b0, 4'h2, 1'b0, 3'd0},
    {8'hF0, 8'h3F, 1'b1, 4'hF, 1'b1, 3'd4},
    {8'h40, 8'hFF, 1'b1, 4'h7, 1'b1, 3'd6}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic ack_once();
    cpu_ack = 1'b1;
    step(1);
    cpu_ack = 1'b0;
  endtask

  // Open all gates and take every offered request; returns how many
  task automatic drain(output int cnt);
    chan_en = 8'hFF;
    glb_en  = 1'b1;
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      #1;
      if (irq_valid) begin
        ack_once();
        cnt++;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cnt;
    rst_n = 1'b0; ext_line = '0; edge_rise = 8'hFF; chan_en = 8'hFF;
    glb_en = 1'b1; nmi_pin = 1'b0; wdog_req = 1'b0; top_src = 1'b0;
    div0 = 1'b0; vec_base = 4'h0; cpu_ack = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1: boot request after reset
    check("R1 valid", 32'(irq_valid), 32'd1);
    check("R1 kind", 32'(kind), 32'd3);
    check("R1 addr", 32'(vec_addr), 32'h0000);
    check("R1 save", 32'(save_flags), 32'd0);
    ack_once();
    check("R1 cleared", 32'(irq_valid), 32'd0);

    // Table: R3 R4 R5 with several line patterns
    for (int v = 0; v < NV; v++) begin
      logic [7:0] fire;
      logic [3:0] base;
      logic [2:0] ech;
      fire = VECS[v][24:17];
      chan_en = VECS[v][16:9];
      glb_en = VECS[v][8];
      base = VECS[v][7:4];
      vec_base = base;
      ech = VECS[v][2:0];
      ext_line = fire;
      step(3);
      check("R4 valid", 32'(irq_valid), 32'(VECS[v][3]));
      if (VECS[v][3]) begin
        check("R5 chan", 32'(chan), 32'(ech));
        check("R3 kind", 32'(kind), 32'd0);
        check("R3 addr", 32'(vec_addr), 32'({ISEG, base, ech, 1'b0}));
        check("R3 save", 32'(save_flags), 32'd1);
      end
      ext_line = '0;
      drain(cnt);
      check("R11 all served", 32'(cnt), 32'($countones(fire)));
      check("R11 empty", 32'(irq_valid), 32'd0);
      step(4);
    end

    // R2: latency of an edge
    vec_base = 4'h2;
    ext_line[5] = 1'b1;
    step(2);
    check("R2 early", 32'(irq_valid), 32'd0);
    step(1);
    check("R2 due", 32'(irq_valid), 32'd1);
    check("R2 chan", 32'(chan), 32'd5);
    ext_line = '0;
    drain(cnt);
    step(4);

    // R2: falling-edge selection ignores the rising edge
    edge_rise[6] = 1'b0;
    ext_line[6] = 1'b1;
    step(5);
    check("R2 rise ignored", 32'(irq_valid), 32'd0);
    ext_line[6] = 1'b0;
    step(3);
    check("R2 fall seen", 32'(irq_valid), 32'd1);
    check("R2 fall chan", 32'(chan), 32'd6);
    drain(cnt);
    edge_rise = 8'hFF;
    step(4);

    // R6 R8: pin source bypasses every gate
    glb_en = 1'b0; chan_en = 8'h00; top_src = 1'b0;
    nmi_pin = 1'b1;
    step(3);
    check("R6 nmi valid", 32'(irq_valid), 32'd1);
    check("R8 kind", 32'(kind), 32'd2);
    check("R8 addr", 32'(vec_addr), 32'({ISEG, 8'h04}));
    check("R8 save", 32'(save_flags), 32'd1);
    ack_once();
    nmi_pin = 1'b0;
    check("R6 cleared", 32'(irq_valid), 32'd0);

    // R7: watchdog source needs the global enable
    top_src = 1'b1;
    wdog_req = 1'b1;
    step(1);
    wdog_req = 1'b0;
    check("R7 held off", 32'(irq_valid), 32'd0);
    glb_en = 1'b1;
    #1;
    check("R7 released", 32'(irq_valid), 32'd1);
    check("R7 kind", 32'(kind), 32'd2);
    step(1);
    ack_once();
    check("R7 cleared", 32'(irq_valid), 32'd0);

    // R9 R10: trap over external, then external remains
    chan_en = 8'hFF;
    ext_line[0] = 1'b1;
    div0 = 1'b1;
    step(1);
    div0 = 1'b0;
    step(2);
    check("R9 kind", 32'(kind), 32'd1);
    check("R9 addr", 32'(vec_addr), 32'({CSEG, 8'h02}));
    check("R9 save", 32'(save_flags), 32'd0);
    ack_once();
    check("R11 ext left", 32'(kind), 32'd0);
    check("R11 ext valid", 32'(irq_valid), 32'd1);
    ack_once();
    ext_line = '0;
    check("R11 done", 32'(irq_valid), 32'd0);

    // R10: top-level over trap
    wdog_req = 1'b1; div0 = 1'b1;
    step(1);
    wdog_req = 1'b0; div0 = 1'b0;
    check("R10 top first", 32'(kind), 32'd2);
    ack_once();
    check("R10 trap next", 32'(kind), 32'd1);
    ack_once();
    check("R10 empty", 32'(irq_valid), 32'd0);

    // R1: reset drops pending work and re-arms boot
    ext_line[2] = 1'b1;
    step(4);
    rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
    ext_line = '0;
    step(1);
    check("R1 reboot kind", 32'(kind), 32'd3);
    ack_once();
    check("R1 pending dropped", 32'(irq_valid), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule